// File: doc/BRIEF.md
# Indirect Index Register Bank

This block holds a small bank of 8-bit configuration registers that cannot be addressed directly. Every access goes through one 16-bit command word. The word carries a write-enable, a read-request flag, a 4-bit index and an 8-bit data field. Once per frame the surrounding serial logic presents a command. The block either updates the addressed register or builds a readback word, and then returns one 16-bit result word for the outgoing status slot.

Alongside the bank, the block keeps a status word that is captured from a live status input only at frame boundaries. The read-request flag picks what the result word carries: the addressed register in command-word layout, or the captured status word. Three of the sixteen index codes have no register behind them. Writes to those codes are dropped, and reads of them fall back to the status word. All configuration registers are exposed as one flat vector, so the rest of the chip can use them.

Top module: `index_reg_bank`

## Requirements
- R1: Command layout: bit 15 is write-enable, bit 14 is read-request, bits 11:8 are the index and bits 7:0 are the data. Bits 13:12 are ignored. A command with bit 15 low changes no register.
- R2: A command with write-enable high and an index other than 11, 14 or 15 loads its data byte into that register at the clock edge that accepts the command. Register n appears on `cfgRegs[n*8 +: 8]` from the next cycle on.
- R3: A write to index 11, 14 or 15 leaves every register unchanged. The slices of `cfgRegs` for those indices always read 8'h00.
- R4: When read-request is 0, the result word equals the captured status word.
- R5: When read-request is 1 and the index is valid, the result word is {1'b0, 1'b1, 2'b00, index, register value}. If the same command also writes, the register value shown is the newly written byte.
- R6: When read-request is 1 and the index is 11, 14 or 15, the result word equals the captured status word.
- R7: The status word is loaded from `statusIn` only in cycles where `frameStart` is high. A command accepted in the same cycle as `frameStart` already sees the newly loaded value. Changes on `statusIn` between boundaries are not seen.
- R8: `outValid` is high for exactly the one cycle after each accepted command. `outWord` holds its last value while no command is accepted.
- R9: After reset, all registers read 8'h00, the status word is 16'h0000, `outValid` is 0 and `outWord` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame boundary strobe; loads the status word |
| statusIn | input | 16 | Live status source |
| cmdValid | input | 1 | A command word is presented this cycle |
| cmdWord | input | 16 | Command word |
| outValid | output | 1 | Result word valid pulse |
| outWord | output | 16 | Readback or status result word |
| cfgRegs | output | 128 | All 16 register slots, slot n at bits n*8+7:n*8 |

## Verification
The hardest case to reach is the ordering between the frame boundary and a command. A status value must be seen only when it was present at a boundary, even if `statusIn` has moved since. It must also be seen at once when the boundary and the command fall in the same cycle. To get there, the stimulus loads one value with a lone boundary pulse and then changes `statusIn` without a boundary, so that a stale capture and a live read give different answers. It then issues a command together with a boundary carrying a third value. Full sweeps over all sixteen indices cover the three missing registers, both for writes and for reads.

// File: rtl/index_reg_bank_pkg.sv
package index_reg_bank_pkg;
  localparam int IDX_W     = 4;
  localparam int DATA_W    = 8;
  localparam int WORD_W    = 16;
  localparam int NUM_SLOTS = 1 << IDX_W;
  localparam int WE_BIT    = 15;
  localparam int RREQ_BIT  = 14;
  localparam int IDX_LSB   = 8;

  typedef struct packed {
    logic              issue;
    logic              doWrite;
    logic              pickReg;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } ctrl_strobes_t;

  function automatic logic [WORD_W-1:0] makeReadback(input logic [IDX_W-1:0] idx,
                                                     input logic [DATA_W-1:0] data);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RREQ_BIT] = 1'b1;
    w[IDX_LSB +: IDX_W] = idx;
    w[DATA_W-1:0] = data;
    return w;
  endfunction
endpackage

// File: rtl/index_reg_bank_ctrl.sv
module index_reg_bank_ctrl
  import index_reg_bank_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] INVALID_MASK = 16'hC800
) (
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  output ctrl_strobes_t     strb
);
  logic [IDX_W-1:0] idx;
  logic             idxOk;
  logic             unusedBits;

  assign idx        = cmdWord[IDX_LSB +: IDX_W];
  assign idxOk      = !INVALID_MASK[idx];
  assign unusedBits = ^cmdWord[IDX_LSB-1+IDX_W+2 -: 2];

  always_comb begin
    strb         = '0;
    strb.issue   = cmdValid;
    strb.doWrite = cmdValid && cmdWord[WE_BIT] && idxOk;
    strb.pickReg = cmdWord[RREQ_BIT] && idxOk;
    strb.idx     = idx;
    strb.data    = cmdWord[DATA_W-1:0];
  end
endmodule

// File: rtl/index_reg_bank_dp.sv
module index_reg_bank_dp
  import index_reg_bank_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] INVALID_MASK = 16'hC800
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic [WORD_W-1:0]           statusIn,
  input  ctrl_strobes_t               strb,
  output logic                        outValid,
  output logic [WORD_W-1:0]           outWord,
  output logic [NUM_SLOTS*DATA_W-1:0] regFlat
);
  logic [WORD_W-1:0] statusQ;
  logic [WORD_W-1:0] statusNow;
  logic [DATA_W-1:0] readData;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    if (!INVALID_MASK[g]) begin : gReal
      logic [DATA_W-1:0] slotQ;
      always_ff @(posedge clk) begin
        if (!rstN) slotQ <= '0;
        else if (strb.doWrite && strb.idx == IDX_W'(g)) slotQ <= strb.data;
      end
      assign regFlat[g*DATA_W +: DATA_W] = slotQ;
    end else begin : gHole
      assign regFlat[g*DATA_W +: DATA_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else if (frameStart) statusQ <= statusIn;
  end

  assign statusNow = frameStart ? statusIn : statusQ;
  assign readData  = strb.doWrite ? strb.data : regFlat[strb.idx*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strb.issue;
      if (strb.issue)
        outWord <= strb.pickReg ? makeReadback(strb.idx, readData) : statusNow;
    end
  end

  // R7: status capture only at boundaries
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(statusQ));
  // R8: no pulse without a command, output word held
  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issue |=> (!outValid && $stable(outWord)));
endmodule

// File: rtl/index_reg_bank.sv
module index_reg_bank
  import index_reg_bank_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] INVALID_MASK = 16'hC800
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic [WORD_W-1:0]           statusIn,
  input  logic                        cmdValid,
  input  logic [WORD_W-1:0]           cmdWord,
  output logic                        outValid,
  output logic [WORD_W-1:0]           outWord,
  output logic [NUM_SLOTS*DATA_W-1:0] cfgRegs
);
  ctrl_strobes_t strb;

  index_reg_bank_ctrl #(.INVALID_MASK(INVALID_MASK)) u_ctrl (
    .cmdValid(cmdValid),
    .cmdWord (cmdWord),
    .strb    (strb)
  );

  index_reg_bank_dp #(.INVALID_MASK(INVALID_MASK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .statusIn  (statusIn),
    .strb      (strb),
    .outValid  (outValid),
    .outWord   (outWord),
    .regFlat   (cfgRegs)
  );

  // R3: a write to a missing index leaves the whole bank untouched
  a_r3_hole_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord[WE_BIT] && INVALID_MASK[cmdWord[IDX_LSB +: IDX_W]]) |=> $stable(cfgRegs));
  // R1: write-enable low changes no register
  a_r1_no_we_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdWord[WE_BIT]) |=> $stable(cfgRegs));
  // R2: valid write lands in its slot
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord[WE_BIT] && !INVALID_MASK[cmdWord[IDX_LSB +: IDX_W]])
    |=> cfgRegs[$past(cmdWord[IDX_LSB +: IDX_W])*DATA_W +: DATA_W] == $past(cmdWord[DATA_W-1:0]));
  // R8: every command yields a pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> outValid);
  // R6: read of a missing index returns status
  a_r6_hole_read_status: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWord[RREQ_BIT] && INVALID_MASK[cmdWord[IDX_LSB +: IDX_W]] && frameStart)
    |=> outWord == $past(statusIn));
endmodule

// File: tb/index_reg_bank_tb.sv
`timescale 1ns/100ps
module index_reg_bank_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         frameStart;
  logic [15:0]  statusIn;
  logic         cmdValid;
  logic [15:0]  cmdWord;
  logic         outValid;
  logic [15:0]  outWord;
  logic [127:0] cfgRegs;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  model [16];
  logic [15:0] statModel;

  always #2.5 clk = ~clk;

  index_reg_bank u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .statusIn(statusIn),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .outValid(outValid),
    .outWord(outWord), .cfgRegs(cfgRegs)
  );

  function automatic bit isHole(input int i);
    return (i == 11) || (i == 14) || (i == 15);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    for (int i = 0; i < 16; i++)
      chk(req, {8'h00, cfgRegs[i*8 +: 8]}, {8'h00, model[i]});
  endtask

  task automatic doCmd(input string req, input logic [15:0] w,
                       input logic fs, input logic [15:0] st);
    logic [15:0] exp;
    int idx;
    idx = int'(w[11:8]);
    if (fs) statModel = st;
    if (w[14] && !isHole(idx))
      exp = {2'b01, 2'b00, w[11:8], (w[15] ? w[7:0] : model[idx])};
    else
      exp = statModel;
    if (w[15] && !isHole(idx)) model[idx] = w[7:0];
    @(negedge clk);
    cmdWord = w; cmdValid = 1'b1; frameStart = fs;
    if (fs) statusIn = st;
    @(negedge clk);
    cmdValid = 1'b0; frameStart = 1'b0;
    chk({req, " R8 pulse"}, {15'h0, outValid}, 16'h0001);
    chk(req, outWord, exp);
    chkRegs(req);
    @(negedge clk);
    chk("R8 single", {15'h0, outValid}, 16'h0000);
    chk("R8 hold", outWord, exp);
  endtask

  task automatic frameOnly(input logic [15:0] st);
    @(negedge clk);
    frameStart = 1'b1; statusIn = st;
    @(negedge clk);
    frameStart = 1'b0;
    statModel = st;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameStart = 1'b0; statusIn = 16'h0; cmdValid = 1'b0; cmdWord = 16'h0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    statModel = 16'h0;
    statusIn = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    statusIn = 16'h0;
    // R9 reset state
    chk("R9 valid", {15'h0, outValid}, 16'h0000);
    chk("R9 word", outWord, 16'h0000);
    chkRegs("R9");
    doCmd("R9 status", 16'h0000, 1'b0, 16'h0);

    frameOnly(16'h1234);
    // R2 / R3 write sweep, bits 13:12 set to show they are ignored (R1)
    for (int i = 0; i < 16; i++)
      doCmd(isHole(i) ? "R3" : "R2", {2'b10, 2'b11, 4'(i), 8'(i * 17 + 5)}, 1'b0, 16'h0);
    // R5 / R6 read sweep, no write
    for (int i = 0; i < 16; i++)
      doCmd(isHole(i) ? "R6" : "R5", {2'b01, 2'b00, 4'(i), 8'hFF}, 1'b0, 16'h0);
    // R1 / R4: write-enable low, status selected
    for (int i = 0; i < 16; i++)
      doCmd("R1 R4", {2'b00, 2'b00, 4'(i), 8'hAA}, 1'b0, 16'h0);
    // R7: capture only at a boundary
    frameOnly(16'hBEEF);
    @(negedge clk); statusIn = 16'h5555;
    doCmd("R7 stale", 16'h0300, 1'b0, 16'h0);
    doCmd("R7 same-cycle", 16'h0300, 1'b1, 16'hC0DE);
    doCmd("R7 hole read", 16'h4B00, 1'b1, 16'h0F0F);
    // R5 write and read in one command
    for (int i = 0; i < 16; i++)
      doCmd(isHole(i) ? "R6 wr+rd" : "R5 wr+rd", {2'b11, 2'b00, 4'(i), ~8'(i * 9)}, 1'b0, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule